// File: doc/BRIEF.md
# Stack-Equipped Register Core

This block is a small multi-cycle processor core. It has five signed 32-bit general registers, a hardware last-in-first-out stack and a private data memory. Each instruction takes two clock cycles. In the first cycle the core presents its program counter on `imem_addr` and latches the 32-bit word that an external instruction store returns on `imem_data`. In the second cycle it executes the instruction.

The instruction set has thirteen operations:
- register arithmetic (add, multiply);
- compare-equal into a third register;
- immediate load;
- data-memory store and fetch;
- stack push and pop;
- two PC-relative branches whose signed skip amount is read from a register.

Two one-cycle event ports make program activity visible. One carries register values for the output instruction. The other carries a debug selector code together with the PC of the debug instruction. The core stops on an end instruction, and it stops with a sticky error flag when the program faults.

Top module: `stack_core`

## Requirements
- R1: Word layout: opcode in bits 31:28, register field A in 27:25, B in 24:22, C in 21:19, signed immediate in 15:0. Opcodes are END=0, ADD=1, MULT=2, STORE=3, FETCH=4, EQU=5, PUSH=6, POP=7, GOTO=8, LOAD=9, OUT=10, IF=11, DEBUG=12. Each instruction spends one cycle being latched and one cycle executing. After a non-branch instruction the PC advances by one.
- R2: Reset clears registers, PC, stack pointer, `halted` and `error`, so `imem_addr` reads 0. Two rising edges after reset is released, an OUT at index 0 has produced its event and `imem_addr` reads 1.
- R3: ADD A,B writes A+B into A. MULT A,B writes the low 32 bits of A*B into A.
- R4: EQU A,B,C writes 1 into C when A equals B, otherwise 0.
- R5: LOAD A,imm writes the sign-extended immediate into A. OUT A raises `out_valid` for one cycle, with the register number on `out_reg` and its value on `out_value`.
- R6: STORE A,imm writes A to data address imm, and FETCH A,imm reads that address into A. An address at or above the data depth (32) halts with `error` set.
- R7: PUSH A places A on the stack and POP A moves the top entry into A, in last-in-first-out order.
- R8: GOTO A sets PC to PC+A, where the register value is signed and the PC is that of the GOTO itself. Skipped instructions produce no events.
- R9: IF A,B moves the PC by the signed value in B only when A holds exactly 1. Any other value in A continues with the next instruction.
- R10: DEBUG imm raises `dbg_valid` for one cycle, with the low three immediate bits on `dbg_code` and the PC of the instruction on `dbg_pc`.
- R11: END sets `halted`. While halted, the PC holds and no further events appear.
- R12: A PUSH to a full stack (16 entries) or a POP from an empty stack halts with `error` set and the PC left on the faulting instruction.
- R13: A branch whose target falls outside 0..199 halts with `error` set and the PC left on the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Program counter, address into the instruction store |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| out_valid | output | 1 | One-cycle pulse for an output instruction |
| out_reg | output | 3 | Register number shown |
| out_value | output | 32 | Register value shown |
| dbg_valid | output | 1 | One-cycle pulse for a debug instruction |
| dbg_code | output | 3 | Debug selector code |
| dbg_pc | output | 8 | PC of the debug instruction |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Core stopped on a fault |

## Verification
The hardest state to reach from the ports is stack overflow. It needs sixteen successful pushes before the faulting one, and nothing outside the core reveals how full the stack is. The stimulus reaches it with a three-instruction backward-branch loop that pushes until the core faults. The bench then checks that the PC stayed on the push. A counted loop with a backward branch and a taken IF also exercises the negative-offset path, and several programs are designed so that skipped instructions would leave visible extra events if they ran.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;

    typedef enum logic [3:0] {
        OP_END   = 4'd0,
        OP_ADD   = 4'd1,
        OP_MULT  = 4'd2,
        OP_STORE = 4'd3,
        OP_FETCH = 4'd4,
        OP_EQU   = 4'd5,
        OP_PUSH  = 4'd6,
        OP_POP   = 4'd7,
        OP_GOTO  = 4'd8,
        OP_LOAD  = 4'd9,
        OP_OUT   = 4'd10,
        OP_IF    = 4'd11,
        OP_DEBUG = 4'd12
    } opcode_e;

    typedef enum logic [1:0] {
        PH_LATCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_STOP  = 2'd2
    } phase_e;

endpackage

// File: rtl/core_lifo.sv
module core_lifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] top,
    output logic             full,
    output logic             empty
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SPW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [SPW-1:0]   sp_d, sp_q;
    logic [AW-1:0]    top_idx;

    assign full    = (sp_q == SPW'(DEPTH));
    assign empty   = (sp_q == '0);
    assign top_idx = AW'(sp_q - SPW'(1));
    assign top     = empty ? '0 : slots[top_idx];

    always_comb begin
        sp_d = sp_q;
        if (push) sp_d = sp_q + SPW'(1);
        else if (pop) sp_d = sp_q - SPW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    always_ff @(posedge clk) begin
        if (push) slots[AW'(sp_q)] <= wdata;
    end

    // R12: the core must never push into a full stack or pop an empty one
    assert_no_push_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_pop_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R7: a push followed by a pop-free cycle leaves the pushed value on top
    assert_push_on_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (top == $past(wdata)));
endmodule

// File: rtl/core_dmem.sv
module core_dmem #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] words [DEPTH];

    assign rdata = words[addr];

    always_ff @(posedge clk) begin
        if (we) words[addr] <= wdata;
    end
endmodule

// File: rtl/stack_core.sv
module stack_core
    import stack_core_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NREG        = 5,
    parameter int IMEM_DEPTH  = 200,
    parameter int DMEM_DEPTH  = 32,
    parameter int STACK_DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [7:0]      imem_addr,
    input  logic [31:0]     imem_data,
    output logic            out_valid,
    output logic [2:0]      out_reg,
    output logic [XLEN-1:0] out_value,
    output logic            dbg_valid,
    output logic [2:0]      dbg_code,
    output logic [7:0]      dbg_pc,
    output logic            halted,
    output logic            error
);
    localparam int PCW = 8;
    localparam int RIW = 3;
    localparam int DAW = $clog2(DMEM_DEPTH);

    typedef struct packed {
        phase_e                      phase;
        logic [PCW-1:0]              pc;
        logic [31:0]                 ir;
        logic [NREG-1:0][XLEN-1:0]   regs;
        logic                        out_valid;
        logic [RIW-1:0]              out_reg;
        logic [XLEN-1:0]             out_value;
        logic                        dbg_valid;
        logic [2:0]                  dbg_code;
        logic [PCW-1:0]              dbg_pc;
        logic                        halted;
        logic                        error;
    } core_state_t;

    core_state_t s_d, s_q;

    opcode_e         op;
    logic [RIW-1:0]  fa, fb, fc;
    logic [XLEN-1:0] imm, a_val, b_val, offset, wr_val;
    logic [RIW-1:0]  wr_idx;
    logic            wr_en, fault, stop, jump, addr_ok;
    logic signed [XLEN:0] target;
    logic            stk_push, stk_pop, stk_full, stk_empty;
    logic [XLEN-1:0] stk_top, dm_rdata;
    logic            dm_we;

    core_lifo #(.DEPTH(STACK_DEPTH), .WIDTH(XLEN)) u_lifo (
        .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
        .wdata(a_val), .top(stk_top), .full(stk_full), .empty(stk_empty)
    );

    core_dmem #(.DEPTH(DMEM_DEPTH), .WIDTH(XLEN)) u_dmem (
        .clk(clk), .we(dm_we), .addr(s_q.ir[DAW-1:0]),
        .wdata(a_val), .rdata(dm_rdata)
    );

    always_comb begin
        op      = opcode_e'(s_q.ir[31:28]);
        fa      = s_q.ir[27:25];
        fb      = s_q.ir[24:22];
        fc      = s_q.ir[21:19];
        imm     = {{(XLEN-16){s_q.ir[15]}}, s_q.ir[15:0]};
        a_val   = (32'(fa) < NREG) ? s_q.regs[fa] : '0;
        b_val   = (32'(fb) < NREG) ? s_q.regs[fb] : '0;
        addr_ok = (32'(s_q.ir[15:0]) < DMEM_DEPTH);
    end

    always_comb begin
        s_d           = s_q;
        s_d.out_valid = 1'b0;
        s_d.dbg_valid = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        dm_we    = 1'b0;
        wr_en    = 1'b0;
        wr_idx   = fa;
        wr_val   = '0;
        fault    = 1'b0;
        stop     = 1'b0;
        jump     = 1'b0;
        offset   = XLEN'(1);
        target   = '0;
        case (s_q.phase)
            PH_LATCH: begin
                s_d.ir    = imem_data;
                s_d.phase = PH_EXEC;
            end
            PH_EXEC: begin
                s_d.phase = PH_LATCH;
                case (op)
                    OP_ADD:   begin wr_en = 1'b1; wr_val = a_val + b_val; end
                    OP_MULT:  begin wr_en = 1'b1; wr_val = a_val * b_val; end
                    OP_STORE: begin
                        if (addr_ok) dm_we = 1'b1;
                        else         fault = 1'b1;
                    end
                    OP_FETCH: begin
                        if (addr_ok) begin wr_en = 1'b1; wr_val = dm_rdata; end
                        else         fault = 1'b1;
                    end
                    OP_EQU: begin
                        wr_en  = 1'b1;
                        wr_idx = fc;
                        wr_val = XLEN'(a_val == b_val);
                    end
                    OP_PUSH: begin
                        if (stk_full) fault = 1'b1;
                        else          stk_push = 1'b1;
                    end
                    OP_POP: begin
                        if (stk_empty) fault = 1'b1;
                        else begin
                            stk_pop = 1'b1;
                            wr_en   = 1'b1;
                            wr_val  = stk_top;
                        end
                    end
                    OP_GOTO:  begin jump = 1'b1; offset = a_val; end
                    OP_LOAD:  begin wr_en = 1'b1; wr_val = imm; end
                    OP_OUT: begin
                        s_d.out_valid = 1'b1;
                        s_d.out_reg   = fa;
                        s_d.out_value = a_val;
                    end
                    OP_IF: begin
                        if (a_val == XLEN'(1)) begin jump = 1'b1; offset = b_val; end
                    end
                    OP_DEBUG: begin
                        s_d.dbg_valid = 1'b1;
                        s_d.dbg_code  = s_q.ir[2:0];
                        s_d.dbg_pc    = s_q.pc;
                    end
                    OP_END:   stop  = 1'b1;
                    default:  fault = 1'b1;
                endcase
                if (wr_en && !fault && (32'(wr_idx) < NREG))
                    s_d.regs[wr_idx] = wr_val;
                target = $signed({{(XLEN+1-PCW){1'b0}}, s_q.pc})
                       + $signed({offset[XLEN-1], offset});
                if (!fault && !stop &&
                    (target[XLEN] || (target[XLEN-1:0] >= XLEN'(IMEM_DEPTH))))
                    fault = 1'b1;
                if (fault) begin
                    s_d.halted = 1'b1;
                    s_d.error  = 1'b1;
                    s_d.phase  = PH_STOP;
                end else if (stop) begin
                    s_d.halted = 1'b1;
                    s_d.phase  = PH_STOP;
                end else begin
                    s_d.pc = target[PCW-1:0];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign imem_addr = s_q.pc;
    assign out_valid = s_q.out_valid;
    assign out_reg   = s_q.out_reg;
    assign out_value = s_q.out_value;
    assign dbg_valid = s_q.dbg_valid;
    assign dbg_code  = s_q.dbg_code;
    assign dbg_pc    = s_q.dbg_pc;
    assign halted    = s_q.halted;
    assign error     = s_q.error;

    // R11: once stopped the core stays stopped, holds its PC and stays silent
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));
    assert_silent_when_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (!out_valid && !dbg_valid));
    // R12 / R13: a fault always stops the core
    assert_error_halts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> halted);
    // R13: the PC never leaves the instruction store
    assert_pc_in_range_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(imem_addr) < IMEM_DEPTH));
    // R1 / R5: two-cycle instructions keep output events to single pulses
    assert_out_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    assert_dbg_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_valid |=> !dbg_valid);
    // R1: the PC only changes at the end of an execute cycle
    assert_pc_moves_on_exec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_LATCH) |=> $stable(imem_addr));
endmodule

// File: tb/stack_core_tb.sv
module stack_core_tb;
    localparam logic [3:0] C_END = 4'd0, C_ADD = 4'd1, C_MULT = 4'd2, C_STORE = 4'd3,
        C_FETCH = 4'd4, C_EQU = 4'd5, C_PUSH = 4'd6, C_POP = 4'd7, C_GOTO = 4'd8,
        C_LOAD = 4'd9, C_OUT = 4'd10, C_IF = 4'd11, C_DEBUG = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [31:0] imem_data;
    logic        out_valid, dbg_valid, halted, error;
    logic [2:0]  out_reg, dbg_code;
    logic [31:0] out_value;
    logic [7:0]  dbg_pc;

    logic [31:0] prog [200];
    int errors = 0;
    int checks = 0;
    int n_out = 0;
    int n_dbg = 0;
    logic [2:0]  ev_reg [64];
    logic [31:0] ev_val [64];
    logic [2:0]  dv_code [8];
    logic [7:0]  dv_pc [8];

    always #5 clk = ~clk;

    assign imem_data = (imem_addr < 8'd200) ? prog[imem_addr] : 32'd0;

    stack_core u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .out_valid(out_valid), .out_reg(out_reg), .out_value(out_value),
        .dbg_valid(dbg_valid), .dbg_code(dbg_code), .dbg_pc(dbg_pc),
        .halted(halted), .error(error)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && n_out < 64) begin
            ev_reg[n_out] = out_reg;
            ev_val[n_out] = out_value;
            n_out++;
        end
        if (rst_n && dbg_valid && n_dbg < 8) begin
            dv_code[n_dbg] = dbg_code;
            dv_pc[n_dbg]   = dbg_pc;
            n_dbg++;
        end
    end

    // expected OUT events of the main program: {register, value}
    localparam logic [34:0] EXP [12] = '{
        {3'd0, 32'd4},             // R3 ADD
        {3'd2, -32'sd120000},      // R3 MULT, negative operand
        {3'd2, 32'd1515098112},    // R3 MULT keeps low 32 bits
        {3'd3, 32'd1},             // R4 EQU equal
        {3'd4, 32'd0},             // R4 EQU unequal
        {3'd4, 32'd1515098112},    // R6 FETCH from top address
        {3'd3, -32'sd3},           // R6 FETCH from address 0
        {3'd0, -32'sd3},           // R7 last pushed pops first
        {3'd1, 32'd9},             // R7
        {3'd4, 32'd4},             // R7 first pushed pops last
        {3'd0, 32'd2},             // R9 IF with value 2 not taken; R8 skip produced nothing
        {3'd2, 32'd32}             // R8 backward loop computes 2^5
    };

    function automatic logic [31:0] enc(logic [3:0] op, int a, int b, int c, int imm);
        return {op, 3'(a), 3'(b), 3'(c), 3'b000, 16'(imm)};
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 200; i++) prog[i] = enc(C_END, 0, 0, 0, 0);
    endtask

    task automatic run_prog(int max_cycles);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        n_out = 0;
        n_dbg = 0;
        rst_n = 1'b1;
        for (int i = 0; i < max_cycles && !halted; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // ---------------- main program ----------------
        clear_prog();
        prog[0]  = enc(C_LOAD, 0, 0, 0, 7);
        prog[1]  = enc(C_LOAD, 1, 0, 0, -3);
        prog[2]  = enc(C_ADD, 0, 1, 0, 0);
        prog[3]  = enc(C_OUT, 0, 0, 0, 0);
        prog[4]  = enc(C_LOAD, 2, 0, 0, -30000);
        prog[5]  = enc(C_MULT, 2, 0, 0, 0);
        prog[6]  = enc(C_OUT, 2, 0, 0, 0);
        prog[7]  = enc(C_MULT, 2, 2, 0, 0);
        prog[8]  = enc(C_OUT, 2, 0, 0, 0);
        prog[9]  = enc(C_EQU, 0, 0, 3, 0);
        prog[10] = enc(C_OUT, 3, 0, 0, 0);
        prog[11] = enc(C_EQU, 0, 1, 4, 0);
        prog[12] = enc(C_OUT, 4, 0, 0, 0);
        prog[13] = enc(C_STORE, 2, 0, 0, 31);
        prog[14] = enc(C_STORE, 1, 0, 0, 0);
        prog[15] = enc(C_FETCH, 4, 0, 0, 31);
        prog[16] = enc(C_OUT, 4, 0, 0, 0);
        prog[17] = enc(C_FETCH, 3, 0, 0, 0);
        prog[18] = enc(C_OUT, 3, 0, 0, 0);
        prog[19] = enc(C_LOAD, 3, 0, 0, 9);
        prog[20] = enc(C_PUSH, 0, 0, 0, 0);
        prog[21] = enc(C_PUSH, 3, 0, 0, 0);
        prog[22] = enc(C_PUSH, 1, 0, 0, 0);
        prog[23] = enc(C_POP, 0, 0, 0, 0);
        prog[24] = enc(C_POP, 1, 0, 0, 0);
        prog[25] = enc(C_POP, 4, 0, 0, 0);
        prog[26] = enc(C_OUT, 0, 0, 0, 0);
        prog[27] = enc(C_OUT, 1, 0, 0, 0);
        prog[28] = enc(C_OUT, 4, 0, 0, 0);
        prog[29] = enc(C_LOAD, 3, 0, 0, 3);
        prog[30] = enc(C_GOTO, 3, 0, 0, 0);
        prog[31] = enc(C_OUT, 3, 0, 0, 0);
        prog[32] = enc(C_OUT, 3, 0, 0, 0);
        prog[33] = enc(C_LOAD, 1, 0, 0, 0);
        prog[34] = enc(C_LOAD, 4, 0, 0, 2);
        prog[35] = enc(C_LOAD, 0, 0, 0, 2);
        prog[36] = enc(C_IF, 0, 4, 0, 0);
        prog[37] = enc(C_OUT, 0, 0, 0, 0);
        prog[38] = enc(C_LOAD, 0, 0, 0, 1);
        prog[39] = enc(C_IF, 0, 4, 0, 0);
        prog[40] = enc(C_OUT, 0, 0, 0, 0);
        prog[41] = enc(C_DEBUG, 0, 0, 0, 4);
        prog[42] = enc(C_LOAD, 2, 0, 0, 1);
        prog[43] = enc(C_LOAD, 1, 0, 0, 5);
        prog[44] = enc(C_LOAD, 0, 0, 0, 2);
        prog[45] = enc(C_LOAD, 4, 0, 0, 0);
        prog[46] = enc(C_EQU, 1, 4, 3, 0);
        prog[47] = enc(C_LOAD, 4, 0, 0, 6);
        prog[48] = enc(C_IF, 3, 4, 0, 0);
        prog[49] = enc(C_MULT, 2, 0, 0, 0);
        prog[50] = enc(C_LOAD, 3, 0, 0, -1);
        prog[51] = enc(C_ADD, 1, 3, 0, 0);
        prog[52] = enc(C_LOAD, 3, 0, 0, -8);
        prog[53] = enc(C_GOTO, 3, 0, 0, 0);
        prog[54] = enc(C_OUT, 2, 0, 0, 0);
        prog[55] = enc(C_END, 0, 0, 0, 0);
        run_prog(3000);
        check(n_out == 12, "R8", "OUT event count (skipped code silent)", n_out, 12);
        for (int i = 0; i < 12; i++) begin
            check(ev_reg[i] == EXP[i][34:32], "R5", $sformatf("event %0d register", i),
                  ev_reg[i], EXP[i][34:32]);
            check(ev_val[i] == EXP[i][31:0], "R3-vec", $sformatf("event %0d value (R3 R4 R6 R7 R8 R9)", i),
                  $signed(ev_val[i]), $signed(EXP[i][31:0]));
        end
        check(n_dbg == 1, "R10", "debug event count", n_dbg, 1);
        check(dv_code[0] == 3'd4, "R10", "debug code", dv_code[0], 4);
        check(dv_pc[0] == 8'd41, "R10", "debug pc", dv_pc[0], 41);
        check(halted == 1'b1 && error == 1'b0, "R11", "END halts cleanly", {halted, error}, 2);
        check(imem_addr == 8'd55, "R11", "PC at END", imem_addr, 55);
        repeat (6) @(negedge clk);
        check(n_out == 12 && n_dbg == 1, "R11", "no events after END", n_out, 12);
        check(imem_addr == 8'd55, "R11", "PC held after END", imem_addr, 55);

        // ---------------- reset state and two-cycle timing ----------------
        clear_prog();
        prog[0] = enc(C_OUT, 4, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(halted == 1'b0 && error == 1'b0, "R2", "flags in reset", {halted, error}, 0);
        check(imem_addr == 8'd0, "R2", "PC in reset", imem_addr, 0);
        n_out = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && imem_addr == 8'd0, "R1", "after first edge", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1", "OUT event on second edge", out_valid, 1);
        check(out_reg == 3'd4 && out_value == 32'd0, "R2", "register cleared by reset",
              out_value, 0);
        check(imem_addr == 8'd1, "R1", "PC advanced by one", imem_addr, 1);
        repeat (6) @(negedge clk);

        // ---------------- stack overflow ----------------
        clear_prog();
        prog[0] = enc(C_LOAD, 0, 0, 0, 1);
        prog[1] = enc(C_PUSH, 0, 0, 0, 0);
        prog[2] = enc(C_LOAD, 1, 0, 0, -1);
        prog[3] = enc(C_GOTO, 1, 0, 0, 0);
        prog[2] = enc(C_LOAD, 1, 0, 0, -2);
        run_prog(2000);
        check(halted && error, "R12", "overflow faults", {halted, error}, 3);
        check(imem_addr == 8'd1, "R12", "PC on faulting PUSH", imem_addr, 1);

        // ---------------- stack underflow ----------------
        clear_prog();
        prog[0] = enc(C_POP, 2, 0, 0, 0);
        run_prog(100);
        check(halted && error, "R12", "underflow faults", {halted, error}, 3);
        check(imem_addr == 8'd0, "R12", "PC on faulting POP", imem_addr, 0);

        // ---------------- branch below zero ----------------
        clear_prog();
        prog[0] = enc(C_LOAD, 0, 0, 0, -5);
        prog[1] = enc(C_GOTO, 0, 0, 0, 0);
        run_prog(100);
        check(halted && error, "R13", "negative target faults", {halted, error}, 3);
        check(imem_addr == 8'd1, "R13", "PC on faulting GOTO", imem_addr, 1);

        // ---------------- branch past the end ----------------
        clear_prog();
        prog[0] = enc(C_LOAD, 0, 0, 0, 1);
        prog[1] = enc(C_LOAD, 1, 0, 0, 199);
        prog[2] = enc(C_IF, 0, 1, 0, 0);
        run_prog(100);
        check(halted && error, "R13", "target 201 faults", {halted, error}, 3);
        check(imem_addr == 8'd2, "R13", "PC on faulting IF", imem_addr, 2);

        // ---------------- data address out of range ----------------
        clear_prog();
        prog[0] = enc(C_STORE, 0, 0, 0, 40);
        run_prog(100);
        check(halted && error, "R6", "store beyond depth faults", {halted, error}, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule